// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the pins of an SPI slave and the shift engine that serves them. It lets the host freeze a serial transfer partway through by pulling a hold input low. While the transfer is frozen, the engine receives no clock edges. It later picks up at exactly the bit where it stopped, so no bit is lost or repeated.

All inputs except hold are assumed to be synchronous to the system clock already. The hold input passes through its own synchronizer chain. The block finds the serial clock edges by comparing the clock level with its previous sample. It then passes each edge to the engine as a one-cycle enable pulse, but only when the transfer is running. On a gated rising edge it also captures the serial input bit for the engine.

Entering and leaving the frozen state depends on the serial clock level:

- If the serial clock is low, the change takes effect at once.
- If the serial clock is high, the change waits for the next falling edge, and that falling edge is swallowed.

The output-enable request from the engine is masked as soon as the synchronized hold level goes low. It is restored as soon as that level goes high, whatever the serial clock is doing.

Top module: `spi_hold_gate`

## Requirements
- R1: While the transfer is running, each rising edge of `sck_i` gives exactly one `sck_rise_en_o` pulse and each falling edge gives exactly one `sck_fall_en_o` pulse. Each pulse is one clock wide and appears one clock after the edge is sampled.
- R2: On every gated rising edge, `si_o` takes the value of `si_i` sampled at that edge. At any other time `si_o` keeps its value.
- R3: If the synchronized hold level goes low (0 = hold) while `sck_i` is low, the transfer freezes at once: `paused_o` goes to 1 and no edge pulses follow.
- R4: If the synchronized hold level goes low while `sck_i` is high, the freeze waits for the next falling edge, and that falling edge gives no pulse. If hold returns high before that falling edge, the freeze is cancelled and the falling edge passes normally.
- R5: If hold returns high while `sck_i` is low, the transfer resumes at once. If `sck_i` is high, resumption waits for the next falling edge, which gives no pulse. `paused_o` stays 1 until the transfer resumes.
- R6: While frozen, transitions on `sck_i` and `si_i` give no pulses and leave `si_o` unchanged.
- R7: `so_oe_o` is 1 only when `so_oe_req_i` is 1, `cs_n_i` is low (0 = selected), and the hold level is high or no transfer is under way. It follows the synchronized hold level without waiting for any `sck_i` edge.
- R8: Hold has no effect unless `cs_n_i` is low and at least one gated rising edge has occurred since selection.
- R9: `cs_n_i` high clears the frozen state and ends the transfer. After the device is selected again, hold is ignored until a new rising edge occurs.
- R10: While `rst` is high, `paused_o`, `sck_rise_en_o`, `sck_fall_en_o` and `si_o` are cleared. The hold synchronizer resets to the "not holding" level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n_i | input | 1 | Chip select, low selects (synchronized) |
| sck_i | input | 1 | Serial clock level (synchronized) |
| si_i | input | 1 | Serial data input (synchronized) |
| hold_n_i | input | 1 | Hold request, low freezes (asynchronous) |
| so_oe_req_i | input | 1 | Output-enable request from the shift engine |
| sck_rise_en_o | output | 1 | Gated rising-edge enable for the engine |
| sck_fall_en_o | output | 1 | Gated falling-edge enable for the engine |
| si_o | output | 1 | Serial input bit captured on gated rising edges |
| so_oe_o | output | 1 | Masked serial output enable |
| paused_o | output | 1 | Transfer frozen (or waiting to resume) |

## Verification
The results have different latencies:

| Result | Due after the stimulus |
|---|---|
| Edge pulses and `si_o` | One clock after `sck_i` changes |
| `so_oe_o` | Two clocks after `hold_n_i` changes (synchronizer depth) |
| `paused_o` | Three clocks after `hold_n_i` changes |

The bench keeps each stimulus step for four clocks and samples on the falling clock edge. It counts the edge pulses seen across the whole step and checks the levels only at the last sample of the step, by which time every latency has elapsed. Each step changes either hold or the serial clock, never both, so the deferred cases see a well-defined clock level.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  // Freeze controller states
  typedef enum logic [1:0] {
    HS_RUN     = 2'd0,  // edges pass through
    HS_PEND_P  = 2'd1,  // hold seen with sck high, freeze at next fall
    HS_PAUSED  = 2'd2,  // frozen
    HS_PEND_R  = 2'd3   // hold released with sck high, resume at next fall
  } hold_state_e;

  localparam int HOLD_SYNC_STAGES = 2;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[LAST-1:0], d_i};
  end

  assign q_o = chain_q[LAST];

endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic rise_i,
  input  logic hold_ok_i,
  output logic gate_o,
  output logic active_o,
  output logic paused_o
);

  hold_state_e state_q, state_d;
  logic        active_q;
  logic        paused_q;
  logic        hold_req;

  // hold only counts inside a selected, started transfer
  assign hold_req = ~cs_n_i & active_q & ~hold_ok_i;

  // edges pass only when running and not being frozen this very cycle
  assign gate_o = ~cs_n_i && (state_q == HS_RUN) && !(hold_req && !sck_i);

  always_comb begin
    state_d = state_q;
    if (cs_n_i) begin
      state_d = HS_RUN;
    end else begin
      unique case (state_q)
        HS_RUN:    if (hold_req) state_d = sck_i ? HS_PEND_P : HS_PAUSED;
        HS_PEND_P: if (hold_ok_i) state_d = HS_RUN;
                   else if (!sck_i) state_d = HS_PAUSED;
        HS_PAUSED: if (hold_ok_i) state_d = sck_i ? HS_PEND_R : HS_RUN;
        HS_PEND_R: if (!hold_ok_i) state_d = HS_PAUSED;
                   else if (!sck_i) state_d = HS_RUN;
        default:   state_d = HS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= HS_RUN;
      active_q <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      paused_q <= (state_d == HS_PAUSED) || (state_d == HS_PEND_R);
      if (cs_n_i)               active_q <= 1'b0;
      else if (rise_i && gate_o) active_q <= 1'b1;
    end
  end

  assign active_o = active_q;
  assign paused_o = paused_q;

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = HOLD_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_n_i,
  input  logic so_oe_req_i,
  output logic sck_rise_en_o,
  output logic sck_fall_en_o,
  output logic si_o,
  output logic so_oe_o,
  output logic paused_o
);

  logic hold_ok;
  logic sck_rise, sck_fall;
  logic gate, active;
  logic rise_q, fall_q, si_q;

  spi_hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (hold_n_i),
    .q_o (hold_ok)
  );

  spi_hold_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (sck_i),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  spi_hold_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cs_n_i    (cs_n_i),
    .sck_i     (sck_i),
    .rise_i    (sck_rise),
    .hold_ok_i (hold_ok),
    .gate_o    (gate),
    .active_o  (active),
    .paused_o  (paused_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      si_q   <= 1'b0;
    end else begin
      rise_q <= sck_rise & gate;
      fall_q <= sck_fall & gate;
      if (sck_rise && gate) si_q <= si_i;
    end
  end

  assign sck_rise_en_o = rise_q;
  assign sck_fall_en_o = fall_q;
  assign si_o          = si_q;

  // immediate output mask from the synchronized hold level
  assign so_oe_o = so_oe_req_i & ~cs_n_i & (hold_ok | ~active);

endmodule

// File: rtl/spi_hold_gate_chk.sv
module spi_hold_gate_chk (
  input logic clk,
  input logic rst,
  input logic cs_n_i,
  input logic si_i,
  input logic so_oe_req_i,
  input logic sck_rise_en_o,
  input logic sck_fall_en_o,
  input logic si_o,
  input logic so_oe_o,
  input logic paused_o
);

  // R1
  edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sck_rise_en_o, sck_fall_en_o}));

  // R2
  si_capture_chk: assert property (@(posedge clk) disable iff (rst)
    sck_rise_en_o |-> (si_o == $past(si_i)));

  // R6
  paused_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    paused_o |=> (!sck_rise_en_o && !sck_fall_en_o));

  // R7
  oe_mask_chk: assert property (@(posedge clk) disable iff (rst)
    so_oe_o |-> (so_oe_req_i && !cs_n_i));

  // R9
  deselect_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> !paused_o);

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!paused_o && !sck_rise_en_o && !sck_fall_en_o && !si_o));

endmodule

bind spi_hold_gate spi_hold_gate_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cs_n_i        (cs_n_i),
  .si_i          (si_i),
  .so_oe_req_i   (so_oe_req_i),
  .sck_rise_en_o (sck_rise_en_o),
  .sck_fall_en_o (sck_fall_en_o),
  .si_o          (si_o),
  .so_oe_o       (so_oe_o),
  .paused_o      (paused_o)
);

// File: tb/spi_hold_gate_test.sv
`timescale 1ns/1ps
module spi_hold_gate_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, oe_req = 1'b1;
  logic rise_en, fall_en, si_o, so_oe, paused;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_hold_gate uut (
    .clk           (clk),
    .rst           (rst),
    .cs_n_i        (cs_n),
    .sck_i         (sck),
    .si_i          (si),
    .hold_n_i      (hold_n),
    .so_oe_req_i   (oe_req),
    .sck_rise_en_o (rise_en),
    .sck_fall_en_o (fall_en),
    .si_o          (si_o),
    .so_oe_o       (so_oe),
    .paused_o      (paused)
  );

  localparam int STEP_CLKS = 4;
  localparam int NSTEP = 23;
  // {cs_n, sck, hold_n, si, oe_req, n_rise[2], n_fall[2], paused, so_oe, si_o}
  localparam logic [11:0] TBL [0:NSTEP-1] = '{
    12'b1_0_1_0_1_00_00_0_0_0,
    12'b0_0_1_0_1_00_00_0_1_0,
    12'b0_0_0_0_1_00_00_0_1_0,
    12'b0_0_1_0_1_00_00_0_1_0,
    12'b0_1_1_1_1_01_00_0_1_1,
    12'b0_0_1_1_1_00_01_0_1_1,
    12'b0_0_0_1_1_00_00_1_0_1,
    12'b0_1_0_0_1_00_00_1_0_1,
    12'b0_0_0_0_1_00_00_1_0_1,
    12'b0_0_1_0_1_00_00_0_1_1,
    12'b0_1_1_0_1_01_00_0_1_0,
    12'b0_1_0_0_1_00_00_0_0_0,
    12'b0_0_0_0_1_00_00_1_0_0,
    12'b0_1_0_1_1_00_00_1_0_0,
    12'b0_1_1_1_1_00_00_1_1_0,
    12'b0_0_1_1_1_00_00_0_1_0,
    12'b0_1_1_1_1_01_00_0_1_1,
    12'b0_0_1_1_1_00_01_0_1_1,
    12'b0_0_0_1_1_00_00_1_0_1,
    12'b1_0_0_1_1_00_00_0_0_1,
    12'b0_0_1_1_1_00_00_0_1_1,
    12'b0_0_0_1_1_00_00_0_1_1,
    12'b0_0_1_1_1_00_00_0_1_1
  };

  function automatic string step_tag(input int i);
    case (i)
      0, 19, 20:  return "R9";
      1, 5, 17:   return "R1";
      2, 3, 21, 22: return "R8";
      4, 10, 16:  return "R2";
      6, 18:      return "R3";
      7, 8, 13:   return "R6";
      9, 15:      return "R5";
      11, 14:     return "R7";
      default:    return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int cnt_r, cnt_f;

  task automatic run_step(input int clks);
    cnt_r = 0;
    cnt_f = 0;
    for (int k = 0; k < clks; k++) begin
      @(negedge clk);
      cnt_r += int'(rise_en);
      cnt_f += int'(fall_en);
    end
  endtask

  logic [11:0] v;

  initial begin
    // reset state, R10
    repeat (3) @(negedge clk);
    chk("R10", "paused in reset", int'(paused), 0);
    chk("R10", "rise in reset", int'(rise_en), 0);
    chk("R10", "si_o in reset", int'(si_o), 0);
    rst = 1'b0;

    for (int i = 0; i < NSTEP; i++) begin
      v = TBL[i];
      cs_n = v[11]; sck = v[10]; hold_n = v[9]; si = v[8]; oe_req = v[7];
      run_step(STEP_CLKS);
      chk(step_tag(i), "rise pulses", cnt_r, int'(v[6:5]));
      chk(step_tag(i), "fall pulses", cnt_f, int'(v[4:3]));
      chk(step_tag(i), "paused", int'(paused), int'(v[2]));
      chk(step_tag(i), "so_oe", int'(so_oe), int'(v[1]));
      chk(step_tag(i), "si_o", int'(si_o), int'(v[0]));
    end

    // R4: hold dropped and raised again while sck high cancels the freeze
    cs_n = 1'b1; run_step(STEP_CLKS);
    cs_n = 1'b0; si = 1'b0; sck = 1'b1; run_step(STEP_CLKS);
    chk("R4", "start rise", cnt_r, 1);
    hold_n = 1'b0; run_step(STEP_CLKS);
    chk("R4", "pending not paused", int'(paused), 0);
    hold_n = 1'b1; run_step(STEP_CLKS);
    sck = 1'b0; run_step(STEP_CLKS);
    chk("R4", "fall after cancel", cnt_f, 1);
    chk("R4", "paused after cancel", int'(paused), 0);

    // R7: no engine request means no enable
    oe_req = 1'b0; run_step(2);
    chk("R7", "so_oe without request", int'(so_oe), 0);
    oe_req = 1'b1; run_step(2);
    chk("R7", "so_oe with request", int'(so_oe), 1);

    // R10: reset during a freeze clears it
    hold_n = 1'b0; run_step(STEP_CLKS);
    chk("R3", "paused before reset", int'(paused), 1);
    rst = 1'b1; run_step(2);
    rst = 1'b0; run_step(STEP_CLKS);
    chk("R10", "paused after reset", int'(paused), 0);
    chk("R10", "si_o after reset", int'(si_o), 0);
    sck = 1'b1; si = 1'b1; run_step(STEP_CLKS);
    chk("R10", "rise after reset with hold low", cnt_r, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule